// File: doc/BRIEF.md
# Hibernate Wakeup and Reset Sequencer

This block runs in an always-on power domain and controls when the main supply is on or off. Software writes a one to the hibernate register. The block then drops its power-enable output and waits on a wakeup pin.

The pin is filtered. A wakeup counts only when the pin has stayed high for a programmable number of slow ticks in a row, which rejects glitches and short presses. Once a wakeup is accepted, the block turns power back on. It keeps its active-low reset output asserted for a second programmable number of ticks, then releases it and returns to normal running.

Both durations are programmed in coarse units of 32 slow ticks. The slow tick is a single-cycle enable in the fast clock domain, typically at 32 kHz. The wakeup pin is a synchronous input, and the block samples it only on tick cycles.

Top module: `hws_hib_seq`

## Requirements
- R1: After reset the state is RUN, `pwr_en` is 1 and `rst_out_n` is 1.
- R2: A write of 1 in data bit 0 to word address 0 in state RUN moves the block to HIBERNATE at that clock edge, so `pwr_en` and `rst_out_n` are 0 from the next cycle. A write with bit 0 equal to 0 changes nothing.
- R3: The filter field is data bits [15:5] at word address 1, giving filter ticks = field × 32. The hold field is data bits [11:5] at word address 2, giving hold ticks = field × 32. All other data bits of both writes are ignored. A value written takes effect from the next clock edge.
- R4: Let N be the larger of the filter ticks and 1. The wakeup is accepted on the tick where the pin has been sampled high on N consecutive ticks. At that edge the state becomes RESET_HOLD, with `pwr_en` = 1 and `rst_out_n` = 0.
- R5: A tick that samples the pin low before acceptance returns the block to HIBERNATE and restarts the count. Cycles without a tick neither count nor clear.
- R6: When the filter ticks are 0, the first tick that samples the pin high is accepted.
- R7: Let M be the larger of the hold ticks and 1. In RESET_HOLD the block returns to RUN, with `rst_out_n` = 1, on the M-th tick counted in that state.
- R8: A hibernate write is ignored in any state other than RUN. This includes the cycle in which RESET_HOLD ends.
- R9: `pwr_state` encodes RUN=0, HIBERNATE=1, FILTER=2 and RESET_HOLD=3. The block enters FILTER from HIBERNATE on the first high tick when N > 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register word address |
| wr_data | input | DATA_W | Register write data |
| tick | input | 1 | Slow tick enable, one cycle wide |
| wake_pin | input | 1 | Wakeup pin, synchronous, active high |
| pwr_en | output | 1 | Main power enable |
| rst_out_n | output | 1 | Active-low reset to the main domain |
| pwr_state | output | 2 | Current sequencer state |

## Verification
Two functions can fall in the same cycle: a hibernate request and the last tick of the reset stretch. The bench provokes this directly by issuing the hibernate write in exactly the cycle of the final hold tick. It judges the result by requiring the block to land in RUN and stay there, with power and reset both released. The random phase also lands register writes on tick cycles, so the old thresholds must still apply at that edge. It also lands pin drops on filter ticks, which must restart the count.

// File: rtl/hws_pkg.sv
package hws_pkg;
   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_HIB  = 2'd1,
      ST_FILT = 2'd2,
      ST_HOLD = 2'd3
   } hws_state_e;

   localparam int unsigned HWS_ADDR_HIB  = 0;
   localparam int unsigned HWS_ADDR_FLT  = 1;
   localparam int unsigned HWS_ADDR_HOLD = 2;
endpackage

// File: rtl/hws_field_reg.sv
module hws_field_reg #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned ADDR   = 1,
   parameter int unsigned LSB    = 5,
   parameter int unsigned W      = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [W-1:0]      field
);
   localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ADDR);

   generate
      if (LSB + W > DATA_W) begin : g_bad
         $error("field does not fit in data word");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         field <= '0;
      else if (wr_en && wr_addr == MY_ADDR)
         field <= wr_data[LSB +: W];
   end
endmodule

// File: rtl/hws_span_cnt.sv
module hws_span_cnt #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic [W-1:0] limit,
   output logic         hit
);
   logic [W-1:0] cnt;
   logic [W:0]   lim_eff;
   logic [W:0]   cnt_nxt;

   always_comb begin
      lim_eff = (limit == '0) ? (W+1)'(1) : {1'b0, limit};
      cnt_nxt = {1'b0, cnt} + (W+1)'(1);
      hit     = step && !clr && (cnt_nxt >= lim_eff);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr || hit)
         cnt <= '0;
      else if (step)
         cnt <= cnt_nxt[W-1:0];
   end

   AST_CNT_CLEARED : assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt == '0); // R5
endmodule

// File: rtl/hws_fsm.sv
module hws_fsm
   import hws_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hib_req,
   input  logic       tick,
   input  logic       wake_pin,
   input  logic       flt_hit,
   input  logic       hold_hit,
   output hws_state_e state
);
   hws_state_e state_nxt;

   always_comb begin
      state_nxt = state;
      unique case (state)
         ST_RUN:  if (hib_req) state_nxt = ST_HIB;
         ST_HIB:  if (tick && wake_pin) state_nxt = flt_hit ? ST_HOLD : ST_FILT;
         ST_FILT: if (tick) begin
                     if (!wake_pin)    state_nxt = ST_HIB;
                     else if (flt_hit) state_nxt = ST_HOLD;
                  end
         ST_HOLD: if (hold_hit) state_nxt = ST_RUN;
         default: state_nxt = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_RUN;
      else        state <= state_nxt;
   end

   AST_HIB_ENTRY : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && hib_req) |=> state == ST_HIB); // R2
   AST_NO_WAKE_NO_PIN : assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_HIB || state == ST_FILT) && !(tick && wake_pin)) |=> state != ST_HOLD); // R4
   AST_FILTER_DROP : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FILT && tick && !wake_pin) |=> state == ST_HIB); // R5
   AST_HOLD_WAITS_TICK : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD && !tick) |=> state == ST_HOLD); // R7
   AST_HIB_IGNORED : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD && hib_req) |=> state != ST_HIB); // R8
endmodule

// File: rtl/hws_hib_seq.sv
module hws_hib_seq
   import hws_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned UNIT_LOG2 = 5,
   parameter int unsigned FLT_W     = 11,
   parameter int unsigned HOLD_W    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tick,
   input  logic              wake_pin,
   output logic              pwr_en,
   output logic              rst_out_n,
   output logic [1:0]        pwr_state
);
   localparam int unsigned FCNT_W = FLT_W + UNIT_LOG2;
   localparam int unsigned HCNT_W = HOLD_W + UNIT_LOG2;
   localparam logic [ADDR_W-1:0] A_HIB = ADDR_W'(HWS_ADDR_HIB);

   generate
      if (ADDR_W < 2) begin : g_addr_chk
         $error("ADDR_W too small for register map");
      end
      if (UNIT_LOG2 + FLT_W > DATA_W || UNIT_LOG2 + HOLD_W > DATA_W) begin : g_fld_chk
         $error("field widths exceed data width");
      end
   endgenerate

   logic [FLT_W-1:0]  flt_field;
   logic [HOLD_W-1:0] hold_field;
   logic              hib_req, flt_hit, hold_hit;
   logic              sleeping;
   hws_state_e        state;

   hws_field_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ADDR(HWS_ADDR_FLT),
                   .LSB(UNIT_LOG2), .W(FLT_W)) u_flt_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .field(flt_field));

   hws_field_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ADDR(HWS_ADDR_HOLD),
                   .LSB(UNIT_LOG2), .W(HOLD_W)) u_hold_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .field(hold_field));

   assign hib_req  = wr_en && (wr_addr == A_HIB) && wr_data[0];
   assign sleeping = (state == ST_HIB) || (state == ST_FILT);

   hws_span_cnt #(.W(FCNT_W)) u_flt_cnt (
      .clk(clk), .rst_n(rst_n),
      .clr(!sleeping || (tick && !wake_pin)),
      .step(sleeping && tick && wake_pin),
      .limit({flt_field, {UNIT_LOG2{1'b0}}}),
      .hit(flt_hit));

   hws_span_cnt #(.W(HCNT_W)) u_hold_cnt (
      .clk(clk), .rst_n(rst_n),
      .clr(state != ST_HOLD),
      .step(state == ST_HOLD && tick),
      .limit({hold_field, {UNIT_LOG2{1'b0}}}),
      .hit(hold_hit));

   hws_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .hib_req(hib_req), .tick(tick),
      .wake_pin(wake_pin), .flt_hit(flt_hit), .hold_hit(hold_hit),
      .state(state));

   assign pwr_en    = (state == ST_RUN) || (state == ST_HOLD);
   assign rst_out_n = (state == ST_RUN);
   assign pwr_state = state;

   AST_RELEASE_FROM_HOLD : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_out_n) |-> $past(pwr_state) == 2'd3); // R7
   AST_WAKE_NEEDS_TICK : assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_en && !tick) |=> !pwr_en); // R4
endmodule

// File: tb/tb_hws_hib_seq.sv
module tb_hws_hib_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        tick = 1'b0;
   logic        wake_pin = 1'b0;
   logic        pwr_en, rst_out_n;
   logic [1:0]  pwr_state;

   int unsigned n_chk = 0, n_fail = 0;
   int unsigned cycles = 0;
   bit          done = 1'b0;

   // bench model state
   int unsigned m_st = 0, m_fc = 0, m_hc = 0, m_flt = 0, m_hold = 0;

   always #5 clk = ~clk;

   hws_hib_seq dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .tick(tick), .wake_pin(wake_pin), .pwr_en(pwr_en),
      .rst_out_n(rst_out_n), .pwr_state(pwr_state));

   function automatic int unsigned atleast1(int unsigned v);
      return (v == 0) ? 1 : v;
   endfunction

   task automatic chk(string req, int unsigned got, int unsigned exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   // expected transition at one edge (uses the field values held before it)
   task automatic model_step(logic t, logic p, logic w, logic [3:0] a, logic [31:0] d);
      int unsigned n_f = atleast1(m_flt * 32);
      int unsigned n_h = atleast1(m_hold * 32);
      case (m_st)
         0: if (w && a == 4'd0 && d[0]) m_st = 1;
         1: if (t && p) begin
               if (n_f <= 1) begin m_st = 3; m_fc = 0; end
               else begin m_st = 2; m_fc = 1; end
            end
         2: if (t) begin
               if (!p) begin m_st = 1; m_fc = 0; end
               else begin
                  m_fc++;
                  if (m_fc >= n_f) begin m_st = 3; m_fc = 0; end
               end
            end
         default: if (t) begin
               m_hc++;
               if (m_hc >= n_h) begin m_st = 0; m_hc = 0; end
            end
      endcase
      if (w && a == 4'd1) m_flt  = int'(d[15:5]);
      if (w && a == 4'd2) m_hold = int'(d[11:5]);
   endtask

   task automatic cyc(string req, logic t, logic p, logic w,
                      logic [3:0] a, logic [31:0] d);
      tick = t; wake_pin = p; wr_en = w; wr_addr = a; wr_data = d;
      @(posedge clk);
      model_step(t, p, w, a, d);
      @(negedge clk);
      cycles++;
      chk({req, " state"}, pwr_state, m_st);
      chk({req, " pwr_en"}, pwr_en, (m_st == 0 || m_st == 3) ? 1 : 0);
      chk({req, " rst_out_n"}, rst_out_n, (m_st == 0) ? 1 : 0);
   endtask

   task automatic idle(string req, int n);
      for (int i = 0; i < n; i++) cyc(req, 1'b0, wake_pin, 1'b0, 4'd0, 32'd0);
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 state", pwr_state, 0);
      chk("R1 pwr_en", pwr_en, 1);
      chk("R1 rst_out_n", rst_out_n, 1);

      // R3 fields with junk in the ignored bits: filter 2 units, hold 2 units
      cyc("R3", 1'b0, 1'b0, 1'b1, 4'd1, 32'hFFFF_005F);
      cyc("R3", 1'b0, 1'b0, 1'b1, 4'd2, 32'hFFFF_F05F);
      // R2 write of zero has no effect, write of one hibernates
      cyc("R2", 1'b0, 1'b0, 1'b1, 4'd0, 32'hFFFF_FFFE);
      cyc("R2", 1'b0, 1'b0, 1'b1, 4'd0, 32'h0000_0001);
      chk("R2 hib", pwr_state, 1);
      // R9 first high tick enters FILTER
      cyc("R9", 1'b1, 1'b1, 1'b0, 4'd0, 32'd0);
      chk("R9 filter", pwr_state, 2);
      for (int i = 0; i < 9; i++) begin
         idle("R5", 1);
         cyc("R5", 1'b1, 1'b1, 1'b0, 4'd0, 32'd0);
      end
      // R5 pin drop on a tick restarts
      cyc("R5", 1'b1, 1'b0, 1'b0, 4'd0, 32'd0);
      chk("R5 back", pwr_state, 1);
      // R4 64 consecutive high ticks
      for (int i = 0; i < 63; i++) cyc("R4", 1'b1, 1'b1, 1'b0, 4'd0, 32'd0);
      chk("R4 not yet", pwr_state, 2);
      cyc("R4", 1'b1, 1'b1, 1'b0, 4'd0, 32'd0);
      chk("R4 accepted", pwr_state, 3);
      // R7 hold of 64 ticks, R8 hibernate write on the final tick
      for (int i = 0; i < 63; i++) cyc("R7", 1'b1, 1'b0, 1'b0, 4'd0, 32'd0);
      chk("R7 still held", rst_out_n, 0);
      cyc("R8", 1'b1, 1'b0, 1'b1, 4'd0, 32'd1);
      chk("R8 released", pwr_state, 0);
      idle("R8", 3);
      chk("R8 stays run", pwr_state, 0);

      // R6 zero filter, zero hold
      cyc("R6", 1'b0, 1'b0, 1'b1, 4'd1, 32'h0000_001F);
      cyc("R6", 1'b0, 1'b0, 1'b1, 4'd2, 32'h0000_001F);
      cyc("R6", 1'b0, 1'b0, 1'b1, 4'd0, 32'd1);
      idle("R6", 2);
      cyc("R6", 1'b1, 1'b1, 1'b0, 4'd0, 32'd0);
      chk("R6 direct hold", pwr_state, 3);
      idle("R7", 2);
      cyc("R7", 1'b1, 1'b1, 1'b0, 4'd0, 32'd0);
      chk("R7 one tick", pwr_state, 0);

      // random phase
      for (int i = 0; i < 6000; i++) begin
         logic t, p, w;
         logic [3:0] a;
         logic [31:0] d;
         t = ($urandom % 3) == 0;
         p = (($urandom % 8) == 0) ? ~wake_pin : wake_pin;
         w = ($urandom % 40) == 0;
         a = 4'($urandom % 4);
         d = $urandom;
         if (a != 4'd0) d[31:7] = $urandom;
         if (a == 4'd1) d[15:7] = '0;
         cyc("R4", t, p, w, a, d);
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule